// File: doc/BRIEF.md
# Keyed Load-Linked / Store-Conditional Reservation Table

This block sits beside a shared memory and decides which load-linked / store-conditional pairs from several requesters succeed. A load-linked command records a reservation (an address plus a key) and hands the key back. A store-conditional command must present the same address and key to be granted its write. Plain writes, which may cover a burst, remove every reservation whose address falls inside their range. Each accepted command produces a response one cycle later. The response carries a verdict, a key for load-linked, and a write-enable for the backing memory. The data array is not part of the block.

Keys come from a wrapping counter. A reservation lives for at most half the key space: when a freshly allocated key sits exactly half the key range away from a stored key, that stored reservation is dropped. When every slot is busy and a load-linked misses, a victim is evicted. The choice is deliberately uneven, to make the table harder to drain on purpose. A pseudo-random word is scanned from its top bit. The position of the first set bit, within a window of `CAP` bits, names the slot, so slot i is taken with probability 1/2^(i+1). A word whose window is all zero instead hands the eviction to a round-robin pointer over the remaining slots.

Top module: `llsc_resv_table`

## Requirements
- R1: After reset, rsp_valid and mem_we are low, no reservation is held, and the first key handed out is 0.
- R2: cmd_ready is always high. Every command with cmd_valid high gets exactly one response, with rsp_valid high in the following cycle. The command code is 2'b00 load-linked, 2'b01 store-conditional, 2'b10 write, and 2'b11 reserved. A reserved command answers rsp_ok=0 with mem_we=0 and has no effect.
- R3: A load-linked whose address matches no valid reservation returns the current counter value as rsp_key with rsp_ok=1 and mem_we=0. It increments the counter (modulo 2^KW) and stores the reservation in the lowest-numbered free slot.
- R4: A load-linked whose address matches a valid reservation returns that reservation's key and allocates nothing, so the next miss receives the next unused counter value.
- R5: A store-conditional whose address and key both match a valid reservation answers rsp_ok=1 with mem_we=1 and removes that reservation. rsp_key is 0 for store-conditional and write responses.
- R6: A store-conditional with no matching address and key answers rsp_ok=0 with mem_we=0 and leaves all reservations intact.
- R7: Of several store-conditionals presenting the same valid address and key, only the first one accepted succeeds.
- R8: A write covering cmd_addr..cmd_addr_end, both ends inclusive, always answers rsp_ok=1 with mem_we=1. It removes every reservation inside the range and keeps every reservation outside it.
- R9: Allocating key K' removes any reservation whose key equals K' XOR 2^(KW-1). A reservation therefore survives 2^(KW-1)-1 further allocations and is lost on the next one.
- R10: A load-linked miss with all ENTRIES slots busy evicts exactly one reservation and installs the new one.
- R11: The evicted slot is i (for i < CAP) when bit LFSR_W-1-i is the highest set bit among the top CAP bits of the random word; slot 0 is taken about half the time. If none of those bits is set, slots CAP..ENTRIES-1 are taken in round-robin order, so every slot can be evicted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Always high |
| cmd_kind | input | 2 | 00 load-linked, 01 store-conditional, 10 write, 11 reserved |
| cmd_addr | input | AW | Address, or burst start for writes |
| cmd_addr_end | input | AW | Burst end for writes (inclusive) |
| cmd_key | input | KW | Key presented by a store-conditional |
| rsp_valid | output | 1 | Response present |
| rsp_ok | output | 1 | Success verdict |
| rsp_key | output | KW | Key returned by load-linked |
| mem_we | output | 1 | Write-enable to the backing memory |

## Verification
The hardest states to reach are key ageing and eviction. Ageing with 32-bit keys would take billions of allocations. The bench therefore builds the table with a 5-bit key and makes a reservation survive exactly 15 and then exactly 16 further allocations. Each of these allocations is a load-linked / store-conditional pair on another address, which keeps the table from filling. Eviction is reached by filling all slots in a known order and adding one more reservation. Each old reservation is then probed by store-conditional to find which one is gone. Several hundred such rounds build a histogram that is checked against the skewed distribution.

// File: rtl/llsc_resv_table.sv
module llsc_resv_table #(
  parameter int ENTRIES = 32,
  parameter int AW = 32,
  parameter int KW = 32,
  parameter int LFSR_W = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter int CAP = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_kind,
  input  logic [AW-1:0] cmd_addr,
  input  logic [AW-1:0] cmd_addr_end,
  input  logic [KW-1:0] cmd_key,
  output logic          rsp_valid,
  output logic          rsp_ok,
  output logic [KW-1:0] rsp_key,
  output logic          mem_we
);
  localparam int IW = $clog2(ENTRIES);
  localparam int RRN = ENTRIES - CAP;
  localparam logic [KW-1:0] HALF = KW'(1) << (KW - 1);
  localparam logic [1:0] K_LL = 2'b00, K_SC = 2'b01, K_WR = 2'b10;

  logic [ENTRIES-1:0] vld;
  logic [AW-1:0]      addr_q [ENTRIES];
  logic [KW-1:0]      key_q  [ENTRIES];
  logic [KW-1:0]      key_ctr;
  logic [LFSR_W-1:0]  lfsr;
  logic [IW-1:0]      rr;

  logic [ENTRIES-1:0] addr_hit, pair_hit, rng_hit, age_hit;
  logic [KW-1:0]      hit_key;
  logic [IW-1:0]      free_idx, clz, victim;
  logic               any_free;

  assign cmd_ready = 1'b1;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign addr_hit[i] = vld[i] && addr_q[i] == cmd_addr;
    assign pair_hit[i] = addr_hit[i] && key_q[i] == cmd_key;
    assign rng_hit[i]  = vld[i] && addr_q[i] >= cmd_addr && addr_q[i] <= cmd_addr_end;
    assign age_hit[i]  = vld[i] && key_q[i] == (key_ctr ^ HALF);
  end

  always_comb begin
    hit_key = '0;
    free_idx = '0;
    any_free = 1'b0;
    clz = IW'(CAP);
    for (int i = 0; i < ENTRIES; i++)
      if (addr_hit[i]) hit_key = hit_key | key_q[i];
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!vld[i]) begin
        free_idx = IW'(i);
        any_free = 1'b1;
      end
    for (int j = CAP - 1; j >= 0; j--)
      if (lfsr[LFSR_W-1-j]) clz = IW'(j);
  end

  assign victim = any_free ? free_idx :
                  (clz < IW'(CAP)) ? clz : IW'(CAP) + rr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      key_ctr <= '0;
      lfsr <= LFSR_W'(1);
      rr <= '0;
      rsp_valid <= 1'b0;
      rsp_ok <= 1'b0;
      rsp_key <= '0;
      mem_we <= 1'b0;
    end else begin
      lfsr <= lfsr[0] ? ((lfsr >> 1) ^ LFSR_TAPS) : (lfsr >> 1);
      rsp_valid <= cmd_valid;
      rsp_ok <= 1'b0;
      rsp_key <= '0;
      mem_we <= 1'b0;
      if (cmd_valid) begin
        case (cmd_kind)
          K_LL: begin
            rsp_ok <= 1'b1;
            if (|addr_hit) begin
              rsp_key <= hit_key;
            end else begin
              vld <= vld & ~age_hit;
              vld[victim] <= 1'b1;
              addr_q[victim] <= cmd_addr;
              key_q[victim] <= key_ctr;
              rsp_key <= key_ctr;
              key_ctr <= key_ctr + 1'b1;
              if (!any_free && clz >= IW'(CAP))
                rr <= (rr == IW'(RRN - 1)) ? '0 : rr + 1'b1;
            end
          end
          K_SC: begin
            if (|pair_hit) begin
              vld <= vld & ~pair_hit;
              rsp_ok <= 1'b1;
              mem_we <= 1'b1;
            end
          end
          K_WR: begin
            vld <= vld & ~rng_hit;
            rsp_ok <= 1'b1;
            mem_we <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module llsc_resv_table_chk #(
  parameter int ENTRIES = 32,
  parameter int KW = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic               cmd_ready,
  input logic [1:0]         cmd_kind,
  input logic               rsp_valid,
  input logic               rsp_ok,
  input logic               mem_we,
  input logic [KW-1:0]      key_ctr,
  input logic [ENTRIES-1:0] addr_hit
);
  assert_ready_R2: assert property (@(posedge clk) disable iff (!rst_n) cmd_ready);
  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> rsp_valid);
  assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !rsp_valid && !mem_we);
  assert_reserved_inert_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind == 2'b11) |=> !rsp_ok && !mem_we);
  assert_ll_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind == 2'b00) |=> rsp_ok && !mem_we);
  assert_key_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (key_ctr == $past(key_ctr)) || (key_ctr == $past(key_ctr) + 1'b1));
  assert_sc_verdict_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind == 2'b01) |=> (mem_we == rsp_ok));
  assert_wr_always_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind == 2'b10) |=> rsp_ok && mem_we);
  assert_unique_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(addr_hit));
endmodule

bind llsc_resv_table llsc_resv_table_chk #(.ENTRIES(ENTRIES), .KW(KW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_kind(cmd_kind), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .mem_we(mem_we),
  .key_ctr(key_ctr), .addr_hit(addr_hit));

// File: tb/llsc_resv_table_tb_top.sv
`timescale 1ns/1ps
module llsc_resv_table_tb_top;
  localparam int ENTRIES = 8, AW = 8, KW = 5, CAP = 3, ROUNDS = 300;
  localparam logic [1:0] LL = 2'b00, SC = 2'b01, WR = 2'b10, RSV = 2'b11;

  logic clk = 0, rst_n = 0, cmd_valid = 0, cmd_ready;
  logic [1:0] cmd_kind = '0;
  logic [AW-1:0] cmd_addr = '0, cmd_addr_end = '0;
  logic [KW-1:0] cmd_key = '0;
  logic rsp_valid, rsp_ok, mem_we;
  logic [KW-1:0] rsp_key;

  int checks = 0, errors = 0, ekey = 0;
  logic r_ok, r_we, r_v;
  logic [KW-1:0] r_key;
  logic [KW-1:0] keys [ENTRIES+1];
  int hist [ENTRIES];

  always #2 clk = ~clk;

  llsc_resv_table #(.ENTRIES(ENTRIES), .AW(AW), .KW(KW), .CAP(CAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_addr_end(cmd_addr_end),
    .cmd_key(cmd_key), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
    .rsp_key(rsp_key), .mem_we(mem_we));

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [1:0] k, input int a, input int ae, input int key);
    cmd_valid = 1; cmd_kind = k; cmd_addr = AW'(a); cmd_addr_end = AW'(ae); cmd_key = KW'(key);
    @(negedge clk);
    r_v = rsp_valid; r_ok = rsp_ok; r_we = mem_we; r_key = rsp_key;
    cmd_valid = 0;
  endtask

  task automatic ll_new(input int a, input string req);
    cmd(LL, a, 0, 0);
    chk(r_v && r_ok && !r_we && r_key == KW'(ekey), req, int'(r_key), ekey % 32);
    ekey = (ekey + 1) % 32;
  endtask

  task automatic sc_exp(input int a, input int key, input bit ok, input string req);
    cmd(SC, a, 0, key);
    chk(r_v && r_ok == ok && r_we == ok && r_key == '0, req, int'(r_ok), int'(ok));
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!rsp_valid && !mem_we, "R1", int'(rsp_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk(cmd_ready && !rsp_valid, "R2", int'(rsp_valid), 0);
    ll_new(8'h10, "R1");
    ll_new(8'h20, "R3");
    cmd(LL, 8'h10, 0, 0);
    chk(r_ok && r_key == 0, "R4", int'(r_key), 0);
    ll_new(8'h30, "R4");
    cmd(RSV, 8'h20, 8'hFF, 1);
    chk(r_v && !r_ok && !r_we, "R2", int'(r_ok), 0);
    @(negedge clk);
    chk(!rsp_valid && !mem_we, "R2", int'(rsp_valid), 0);
    sc_exp(8'h20, 0, 0, "R6");
    sc_exp(8'h40, 1, 0, "R6");
    sc_exp(8'h20, 1, 1, "R5");
    sc_exp(8'h20, 1, 0, "R7");
    ll_new(8'h50, "R3");
    cmd(LL, 8'h50, 0, 0);
    chk(r_key == 3, "R4", int'(r_key), 3);
    sc_exp(8'h50, 3, 1, "R7");
    sc_exp(8'h50, 3, 0, "R7");
    ll_new(8'h60, "R3");
    ll_new(8'h70, "R3");
    cmd(WR, 8'h30, 8'h60, 0);
    chk(r_v && r_ok && r_we && r_key == '0, "R8", int'(r_we), 1);
    sc_exp(8'h30, 2, 0, "R8");
    sc_exp(8'h60, 4, 0, "R8");
    sc_exp(8'h10, 0, 1, "R8");
    sc_exp(8'h70, 5, 1, "R8");
    ll_new(8'h80, "R3");
    cmd(WR, 8'h81, 8'h90, 0);
    chk(r_ok && r_we, "R8", int'(r_we), 1);
    sc_exp(8'h80, 6, 1, "R8");

    // ageing: 15 further allocations survive, the 16th drops it
    for (int pass = 0; pass < 2; pass++) begin
      int kept;
      kept = ekey;
      ll_new(8'hA0, "R9");
      for (int n = 0; n < 15 + pass; n++) begin
        int k;
        k = ekey;
        ll_new(8'hC0 + n, "R9");
        sc_exp(8'hC0 + n, k, 1, "R9");
      end
      sc_exp(8'hA0, kept, pass == 0, "R9");
    end

    for (int s = 0; s < ENTRIES; s++) hist[s] = 0;
    for (int r = 0; r < ROUNDS; r++) begin
      int fails, slot;
      fails = 0; slot = -1;
      for (int s = 0; s <= ENTRIES; s++) begin
        keys[s] = KW'(ekey);
        ll_new(s, s == ENTRIES ? "R10" : "R3");
      end
      for (int s = 0; s <= ENTRIES; s++) begin
        cmd(SC, s, 0, int'(keys[s]));
        if (s == ENTRIES) chk(r_ok, "R10", int'(r_ok), 1);
        else if (!r_ok) begin fails++; slot = s; end
      end
      chk(fails == 1, "R10", fails, 1);
      if (slot >= 0) hist[slot]++;
    end
    chk(hist[0] > ROUNDS * 3 / 10 && hist[0] < ROUNDS * 7 / 10, "R11", hist[0], ROUNDS / 2);
    chk(hist[1] > ROUNDS / 10 && hist[1] < ROUNDS * 4 / 10, "R11", hist[1], ROUNDS / 4);
    chk(hist[0] > hist[1] && hist[1] > hist[2], "R11", hist[2], hist[1]);
    for (int s = 0; s < ENTRIES; s++)
      chk(hist[s] > 0, "R11", hist[s], 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule